// File: doc/BRIEF.md
# Predicated Contiguous Byte Prefetch Sequencer

This block turns one decoded vector prefetch instruction into a stream of single-address prefetch requests. A start pulse captures a 32-bit instruction word, a general-register base value, a stack-pointer value, a 64-bit index and a byte-granular predicate mask. The vector length is a parameter, so the mask has one bit per byte element. The block then walks the active elements from lowest to highest. For each one it issues a request that carries an address, a read-or-write hint, a target cache level and a streaming flag.

Element `e` addresses the byte at base plus index plus `e`, with wraparound at 64 bits. The captured index is only read and is never written back. The instruction word is checked against its fixed opcode bits. An undefined or malformed encoding, or a hint with no level, completes without any request. Requests leave on a valid/ready handshake, and a busy/done pair reports when the sequence is over.

Top module: `vec_prefetch_seq`

## Requirements
- R1: A start word whose fixed bits differ from bits[31:21]=10000100000, bits[15:13]=110, bit[4]=0 issues no request. In the cycle after start, done and encErr are both 1 and busy is 0.
- R2: A start word whose offset-register field bits[20:16] equals 5'b11111 is undefined. It issues no request and raises encErr together with done in the cycle after start.
- R3: When the base-register field bits[9:5] equals 31, the base comes from spBase. Otherwise it comes from gprBase.
- R4: The request for element e carries address base + index + e, modulo 2^64. Requests come out in ascending element order, at most one per cycle.
- R5: Elements whose predMask bit is 0 produce no request. An all-zero mask gives done in the cycle after start, with no request and no error.
- R6: Each request carries reqWrite = bits[3], reqLevel = bits[2:1] (0 = L1, 1 = L2, 2 = L3) and reqStream = bits[0] of the operation field of the word.
- R7: An operation field with bits[2:1] = 11 is a reserved hint. It issues no request and gives done without encErr in the cycle after start.
- R8: While reqValid is 1 and reqReady is 0, reqValid stays 1 and the address and hint outputs hold their values.
- R9: busy rises in the cycle after an accepted start with a non-empty legal operation. It stays high until the last request is accepted, and then falls with a one-cycle done. reqValid is never 1 while busy is 0.
- R10: A start pulse that arrives while busy is 1 is ignored. The sequence in progress goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture operands and begin a sequence (ignored while busy) |
| instWord | input | 32 | Prefetch instruction word |
| gprBase | input | 64 | Base value from the general register |
| spBase | input | 64 | Base value from the stack pointer |
| idxVal | input | 64 | Index value |
| predMask | input | VLEN/8 | Predicate, one bit per byte element |
| reqValid | output | 1 | Request valid |
| reqReady | input | 1 | Request accepted by the consumer |
| reqAddr | output | 64 | Prefetch byte address |
| reqWrite | output | 1 | 1 = prefetch for write, 0 = for read |
| reqLevel | output | 2 | Target cache level minus one |
| reqStream | output | 1 | 1 = streaming, 0 = keep |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| encErr | output | 1 | Undefined encoding, valid together with done |

## Verification
The hardest situation to reach is a long run of back-pressure on a sparse mask. There the pending-element pointer must skip many gaps while the held request stays frozen, and a second start must arrive in the middle of that run. The stimulus drops reqReady at random about a third of the time. It mixes dense, sparse and single-bit random masks, and in a directed case it fires an interfering start one cycle into a sequence. Addresses near the 64-bit boundary and the stack-pointer base select are covered by directed operations.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic load;     // capture operands and mask
    logic advance;  // current element accepted, retire it
  } vpfStrobe_t;

  typedef struct packed {
    logic       write;
    logic [1:0] level;
    logic       stream;
  } vpfHint_t;

  localparam logic [10:0] OPC_HI  = 11'b10000100000;
  localparam logic [2:0]  OPC_MID = 3'b110;

  // Fixed-bit mismatch or undefined offset register
  function automatic logic encBad(input logic [31:0] w);
    return (w[31:21] != OPC_HI) || (w[15:13] != OPC_MID) || w[4] ||
           (w[20:16] == 5'b11111);
  endfunction

  // Immediate-only hint form: no level, treated as no-op
  function automatic logic hintNop(input logic [31:0] w);
    return w[2:1] == 2'b11;
  endfunction
endpackage

// File: rtl/vpf_dpath.sv
module vpf_dpath
  import vpf_pkg::*;
#(
  parameter int VLEN  = 256,
  parameter int NELEM = VLEN / 8,
  localparam int EW   = $clog2(NELEM)
) (
  input  logic             clk,
  input  logic             rstN,
  input  vpfStrobe_t       strobe,
  input  logic [31:0]      instWord,
  input  logic [63:0]      gprBase,
  input  logic [63:0]      spBase,
  input  logic [63:0]      idxVal,
  input  logic [NELEM-1:0] predMask,
  output logic [63:0]      reqAddr,
  output vpfHint_t         hint,
  output logic             anyLeft,
  output logic             lastLeft
);
  logic [63:0]      baseQ, idxQ;
  vpfHint_t         hintQ;
  logic [NELEM-1:0] pendQ;
  logic [EW-1:0]    curEl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      idxQ  <= '0;
      hintQ <= '0;
      pendQ <= '0;
    end else if (strobe.load) begin
      baseQ <= (instWord[9:5] == 5'd31) ? spBase : gprBase;
      idxQ  <= idxVal;
      hintQ <= '{write: instWord[3], level: instWord[2:1], stream: instWord[0]};
      pendQ <= predMask;
    end else if (strobe.advance) begin
      pendQ <= pendQ & (pendQ - 1'b1);  // retire lowest pending element
    end
  end

  // Lowest pending element
  always_comb begin
    curEl = '0;
    for (int i = NELEM - 1; i >= 0; i--)
      if (pendQ[i]) curEl = EW'(i);
  end

  assign anyLeft  = |pendQ;
  assign lastLeft = ((pendQ & (pendQ - 1'b1)) == '0);
  assign reqAddr  = baseQ + idxQ + 64'(curEl);
  assign hint     = hintQ;
endmodule

// File: rtl/vpf_ctrl.sv
module vpf_ctrl
  import vpf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] instWord,
  input  logic        maskAny,
  input  logic        anyLeft,
  input  logic        lastLeft,
  input  logic        reqReady,
  output vpfStrobe_t  strobe,
  output logic        reqValid,
  output logic        busy,
  output logic        done,
  output logic        encErr
);
  logic busyQ, doneQ, errQ;
  logic accept, bad, go, fire;

  assign accept   = start && !busyQ;
  assign bad      = encBad(instWord);
  assign go       = accept && !bad && !hintNop(instWord) && maskAny;
  assign reqValid = busyQ && anyLeft;
  assign fire     = reqValid && reqReady;

  assign strobe.load    = go;
  assign strobe.advance = fire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      if (accept && !go) begin
        doneQ <= 1'b1;
        errQ  <= bad;
      end else if (go) begin
        busyQ <= 1'b1;
      end else if (fire && lastLeft) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end
    end
  end

  assign busy   = busyQ;
  assign done   = doneQ;
  assign encErr = errQ;
endmodule

// File: rtl/vec_prefetch_seq.sv
module vec_prefetch_seq
  import vpf_pkg::*;
#(
  parameter int VLEN   = 256,
  localparam int NELEM = VLEN / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [31:0]      instWord,
  input  logic [63:0]      gprBase,
  input  logic [63:0]      spBase,
  input  logic [63:0]      idxVal,
  input  logic [NELEM-1:0] predMask,
  output logic             reqValid,
  input  logic             reqReady,
  output logic [63:0]      reqAddr,
  output logic             reqWrite,
  output logic [1:0]       reqLevel,
  output logic             reqStream,
  output logic             busy,
  output logic             done,
  output logic             encErr
);
  vpfStrobe_t strobe;
  vpfHint_t   hint;
  logic       anyLeft, lastLeft;

  vpf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .instWord(instWord),
    .maskAny(|predMask), .anyLeft(anyLeft), .lastLeft(lastLeft),
    .reqReady(reqReady), .strobe(strobe), .reqValid(reqValid),
    .busy(busy), .done(done), .encErr(encErr)
  );

  vpf_dpath #(.VLEN(VLEN)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instWord(instWord),
    .gprBase(gprBase), .spBase(spBase), .idxVal(idxVal),
    .predMask(predMask), .reqAddr(reqAddr), .hint(hint),
    .anyLeft(anyLeft), .lastLeft(lastLeft)
  );

  assign reqWrite  = hint.write;
  assign reqLevel  = hint.level;
  assign reqStream = hint.stream;
endmodule

// File: rtl/vec_prefetch_seq_chk.sv
module vec_prefetch_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [31:0] instWord,
  input logic        reqValid,
  input logic        reqReady,
  input logic [63:0] reqAddr,
  input logic        reqWrite,
  input logic [1:0]  reqLevel,
  input logic        reqStream,
  input logic        busy,
  input logic        done,
  input logic        encErr
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqWrite)
                              && $stable(reqLevel) && $stable(reqStream));

  // R9
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> busy);

  // R9
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R2
  rm_undef_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && (instWord[20:16] == 5'b11111) |=> encErr && done && !busy);

  // R1
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    encErr |-> done && !reqValid);
endmodule

bind vec_prefetch_seq vec_prefetch_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .instWord(instWord),
  .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
  .reqWrite(reqWrite), .reqLevel(reqLevel), .reqStream(reqStream),
  .busy(busy), .done(done), .encErr(encErr)
);

// File: tb/vec_prefetch_seq_tb.sv
module vec_prefetch_seq_tb;
  localparam int VLEN  = 256;
  localparam int NELEM = VLEN / 8;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, reqReady = 1'b0;
  logic [31:0] instWord = '0;
  logic [63:0] gprBase = '0, spBase = '0, idxVal = '0;
  logic [NELEM-1:0] predMask = '0;
  logic reqValid, reqWrite, reqStream, busy, done, encErr;
  logic [1:0]  reqLevel;
  logic [63:0] reqAddr;

  int nChk = 0, nBad = 0;

  always #4 clk = ~clk;  // 125 MHz

  vec_prefetch_seq #(.VLEN(VLEN)) u_dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  function automatic logic [31:0] mkInst(input logic [4:0] rm, input logic [2:0] pg,
                                         input logic [4:0] rn, input logic [3:0] op);
    return {11'b10000100000, rm, 3'b110, pg, rn, 1'b0, op};
  endfunction

  function automatic bit expBad(input logic [31:0] w);
    return (w[31:21] != 11'b10000100000) || (w[15:13] != 3'b110) || w[4] ||
           (w[20:16] == 5'd31);
  endfunction

  task automatic runOp(input logic [31:0] w, input logic [63:0] gpr, input logic [63:0] sp,
                       input logic [63:0] idx, input logic [NELEM-1:0] mask,
                       input bit interfere, input string tag);
    logic [63:0] expAddr[NELEM];
    logic [63:0] base;
    int expN = 0, got = 0;
    bit bad, sawDone = 0;
    bad  = expBad(w);
    base = (w[9:5] == 5'd31) ? sp : gpr;
    if (!bad && w[2:1] != 2'b11)
      for (int e = 0; e < NELEM; e++)
        if (mask[e]) begin expAddr[expN] = base + idx + 64'(e); expN++; end
    @(negedge clk);
    instWord = w; gprBase = gpr; spBase = sp; idxVal = idx; predMask = mask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (done) begin
        sawDone = 1;
        chk(tag, "encErr at done", 64'(encErr), 64'(bad));
        chk("R9", "busy low at done", 64'(busy), 64'd0);
        chk(tag, "request count", 64'(got), 64'(expN));
        break;
      end
      if (interfere && cyc == 1) begin  // R10: start while busy
        start = 1'b1; instWord = mkInst(5'd1, 3'd0, 5'd2, 4'b0000);
        predMask = '1; gprBase = 64'h1234;
      end else start = 1'b0;
      reqReady = ($urandom % 10) < 7;
      if (reqValid && reqReady) begin
        if (got < expN) begin
          chk(tag, "addr R4", reqAddr, expAddr[got]);
          chk("R6", "hint", {60'd0, reqWrite, reqLevel, reqStream}, {60'd0, w[3:0]});
        end else chk(tag, "extra request", 64'(got), 64'(expN));
        got++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (!sawDone) chk(tag, "done seen", 64'd0, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [NELEM-1:0] m;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk("R9", "reset busy", 64'(busy), 64'd0);
    chk("R9", "reset valid", 64'(reqValid), 64'd0);
    chk("R9", "reset done", 64'(done), 64'd0);
    rstN = 1'b1;
    runOp(mkInst(5'd4, 3'd1, 5'd3, 4'b0000), 64'h1000, 64'h9000, 64'h20, '1, 0, "R4");
    runOp(mkInst(5'd4, 3'd1, 5'd31, 4'b1011), 64'h1000, 64'h9000, 64'h5, 32'h8000_0001, 0, "R3");
    runOp(mkInst(5'd2, 3'd0, 5'd7, 4'b0101), 64'hFFFF_FFFF_FFFF_FFF0, 0, 64'h8,
          32'hF000_F00F, 0, "R4");
    runOp(mkInst(5'd2, 3'd0, 5'd7, 4'b0000), 64'h40, 0, 0, '0, 0, "R5");
    runOp(mkInst(5'd2, 3'd0, 5'd7, 4'b0000), 64'h40, 0, 0, 32'h8000_0000, 0, "R5");
    runOp(mkInst(5'd31, 3'd0, 5'd7, 4'b0000), 64'h40, 0, 0, '1, 0, "R2");
    runOp(mkInst(5'd2, 3'd0, 5'd7, 4'b0000) | 32'h10, 64'h40, 0, 0, '1, 0, "R1");
    runOp(mkInst(5'd2, 3'd0, 5'd7, 4'b0000) ^ 32'h4000, 64'h40, 0, 0, '1, 0, "R1");
    runOp(mkInst(5'd2, 3'd0, 5'd7, 4'b0000) ^ 32'h8000_0000, 64'h40, 0, 0, '1, 0, "R1");
    runOp(mkInst(5'd2, 3'd0, 5'd7, 4'b0110), 64'h40, 0, 0, '1, 0, "R7");
    runOp(mkInst(5'd2, 3'd0, 5'd7, 4'b1111), 64'h40, 0, 0, '1, 0, "R7");
    runOp(mkInst(5'd9, 3'd2, 5'd1, 4'b1000), 64'h7700, 0, 64'h3, 32'h0000_0F0F, 1, "R10");
    for (int i = 0; i < 40; i++) begin
      case ($urandom % 3)
        0: m = $urandom;
        1: m = $urandom & $urandom & $urandom;
        default: m = NELEM'(1) << ($urandom % NELEM);
      endcase
      runOp(mkInst(5'($urandom % 31), 3'($urandom), 5'($urandom),
                   {1'($urandom), 2'($urandom % 3), 1'($urandom)}),
            {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, m, 0, "R4");
    end
    summary();
  end
endmodule